// File: doc/BRIEF.md
# Link Power-Up Timing Monitor

This block watches the power-up and reset sequence of a link endpoint whose fabric is loaded over the link. It sees a few inputs: a strobe when the first supply starts to ramp, a supplies-good level, the internal power-on reset release, the active-low host reset, a periphery-configured flag, a link-training flag and a link-active flag. From these it times six separate intervals, each from its own reference edge, and sets one sticky violation bit for each interval that breaks its limit.

All intervals are counted in whole milliseconds. A prescaler turns `TICKS_PER_MS` clock cycles into one millisecond tick, so a testbench can shrink every interval by choosing a small value. A done output shows that the link has been seen active. A pass output shows that the sequence is done and no violation is set. The supplies themselves and link training are not handled here. Only their indicator signals are observed.

Top module: `lpm_pwrup_mon`

## Requirements
- R1: If `supplies_good` does not rise within `RAMP_MAX_MS` (10) ms of a `ramp_start` strobe, `viol[0]` is set.
- R2: The delay from the rise of `supplies_good` to the rise of `por_released` must lie within `POR_MIN_MS` (4) to `POR_MAX_MS` (12) ms. An early release or a late release sets `viol[1]`.
- R3: The host reset must stay low for at least `HRST_MIN_MS` (100) ms, or `viol[2]` is set when it rises. If `host_rst_n` is low when the monitor comes out of reset, that counts as the start of the low period.
- R4: If `link_training` rises less than `QUIET_MIN_MS` (20) ms after the host reset is released, that is early training and sets `viol[3]`.
- R5: If `periph_ready` does not rise within `PERIPH_MAX_MS` (120) ms of the `ramp_start` strobe, `viol[4]` is set.
- R6: If `link_up` does not rise within `LINK_MAX_MS` (100) ms of the host reset release, `viol[5]` is set.
- R7: Violation bits are sticky. Only a one-cycle `viol_clr` (or `rst_n`) clears them, and the clear wins over a violation in the same cycle.
- R8: `seq_done` goes high the cycle after `link_up` is seen high. It stays high until `rst_n`.
- R9: `seq_pass` is high exactly when `seq_done` is high and every bit of `viol` is zero.
- R10: One millisecond equals `TICKS_PER_MS` clock cycles. Limits are resolved to one millisecond, so an event within about 1 ms of a limit may fall on either side.
- R11: After reset, `viol`, `seq_done` and `seq_pass` are all zero.
- R12: A closing edge that arrives while its interval is not running is ignored and sets no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the monitor |
| viol_clr | input | 1 | Synchronous clear of all violation bits |
| ramp_start | input | 1 | One-cycle strobe: first supply starts ramping |
| supplies_good | input | 1 | All supplies within operating range |
| por_released | input | 1 | Internal power-on reset released |
| host_rst_n | input | 1 | Host reset, active low |
| periph_ready | input | 1 | Periphery configuration complete |
| link_training | input | 1 | Link training has begun |
| link_up | input | 1 | Link in active state |
| viol | output | 6 | Sticky violation bits, one per interval (index as in R1..R6) |
| seq_done | output | 1 | Link-active state observed |
| seq_pass | output | 1 | Done and no violation set |

## Verification
The bench drives three sequences. The first is a compliant power-up, with every interval well inside its limit. It must end with done, pass and no violation set, which shows that the limits do not fire falsely. The second breaks every interval at once: a slow ramp, an early power-on-reset release, a short host reset, early training, and a missing periphery flag and link-active flag. Here the bench checks the violation vector in stages, which shows that each bit belongs to its own interval and that the late bits wait for their own deadlines. It also checks the clear, the pass after a clear, and a closing edge that arrives while its interval is idle. The third sequence gives a late power-on-reset release alone, which tells the upper bound of that interval apart from its lower bound.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   localparam int unsigned NWIN   = 6;
   localparam int unsigned W_RAMP = 0;
   localparam int unsigned W_POR  = 1;
   localparam int unsigned W_HRST = 2;
   localparam int unsigned W_QUIET = 3;
   localparam int unsigned W_PERIPH = 4;
   localparam int unsigned W_LINK = 5;

   // edge detector lane indices
   localparam int unsigned NSIG   = 6;
   localparam int unsigned S_SUPG = 0;
   localparam int unsigned S_POR  = 1;
   localparam int unsigned S_HOST = 2;
   localparam int unsigned S_PERI = 3;
   localparam int unsigned S_TRN  = 4;
   localparam int unsigned S_LINK = 5;

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/lpm_tick_gen.sv
module lpm_tick_gen #(
   parameter int unsigned TICKS_PER_MS = 125000
) (
   input  logic clk,
   input  logic rst_n,
   output logic ms_tick
);
   localparam int unsigned PW = (TICKS_PER_MS < 2) ? 1 : $clog2(TICKS_PER_MS);
   localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MS - 1);

   if (TICKS_PER_MS < 1) begin : g_bad_tpm
      $error("TICKS_PER_MS must be at least 1");
   end

   logic [PW-1:0] pre_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (pre_q == LAST) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   assign ms_tick = (pre_q == LAST);
endmodule

// File: rtl/lpm_edge_det.sv
module lpm_edge_det #(
   parameter int unsigned N = 6,
   parameter logic [N-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= INIT;
      else        prev_q <= lvl;
   end

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign rise[i] = lvl[i] & ~prev_q[i];
      assign fall[i] = ~lvl[i] & prev_q[i];
   end
endmodule

// File: rtl/lpm_window.sv
module lpm_window #(
   parameter int unsigned TW        = 8,
   parameter int unsigned MIN_MS    = 0,
   parameter int unsigned MAX_MS    = 0,
   parameter bit          CHECK_MIN = 1'b0,
   parameter bit          CHECK_MAX = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ms_tick,
   input  logic open_ev,
   input  logic close_ev,
   output logic bad
);
   if (!CHECK_MIN && !CHECK_MAX) begin : g_bad_cfg
      $error("window checks neither bound");
   end
   if ((MIN_MS + 2) > (1 << TW) || (MAX_MS + 2) > (1 << TW)) begin : g_bad_w
      $error("limit does not fit the elapsed counter");
   end

   localparam logic [TW-1:0] SAT = '1;

   logic          run_q;
   logic [TW-1:0] elap_q;
   logic          early_hit;
   logic          late_hit;
   logic          bad_q;

   if (CHECK_MIN) begin : g_min
      assign early_hit = run_q & close_ev & (elap_q < TW'(MIN_MS));
   end else begin : g_nomin
      assign early_hit = 1'b0;
   end

   if (CHECK_MAX) begin : g_max
      assign late_hit = run_q & ~close_ev & (elap_q > TW'(MAX_MS));
   end else begin : g_nomax
      assign late_hit = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         elap_q <= '0;
      end else if ((run_q && close_ev) || late_hit) begin
         run_q  <= 1'b0;
      end else if (open_ev) begin
         run_q  <= 1'b1;
         elap_q <= '0;
      end else if (run_q && ms_tick && elap_q != SAT) begin
         elap_q <= elap_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     bad_q <= 1'b0;
      else if (clr)                   bad_q <= 1'b0;
      else if (early_hit || late_hit) bad_q <= 1'b1;
   end

   assign bad = bad_q;
endmodule

// File: rtl/lpm_pwrup_mon.sv
module lpm_pwrup_mon
   import lpm_pkg::*;
#(
   parameter int unsigned TICKS_PER_MS  = 125000,
   parameter int unsigned RAMP_MAX_MS   = 10,
   parameter int unsigned POR_MIN_MS    = 4,
   parameter int unsigned POR_MAX_MS    = 12,
   parameter int unsigned HRST_MIN_MS   = 100,
   parameter int unsigned QUIET_MIN_MS  = 20,
   parameter int unsigned PERIPH_MAX_MS = 120,
   parameter int unsigned LINK_MAX_MS   = 100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            viol_clr,
   input  logic            ramp_start,
   input  logic            supplies_good,
   input  logic            por_released,
   input  logic            host_rst_n,
   input  logic            periph_ready,
   input  logic            link_training,
   input  logic            link_up,
   output logic [NWIN-1:0] viol,
   output logic            seq_done,
   output logic            seq_pass
);
   localparam int unsigned LIM_TOP = imax(imax(imax(RAMP_MAX_MS, POR_MAX_MS), imax(HRST_MIN_MS, QUIET_MIN_MS)),
                                          imax(PERIPH_MAX_MS, LINK_MAX_MS));
   localparam int unsigned TW = $clog2(LIM_TOP + 2);

   localparam int unsigned LMIN [NWIN] = '{0, POR_MIN_MS, HRST_MIN_MS, QUIET_MIN_MS, 0, 0};
   localparam int unsigned LMAX [NWIN] = '{RAMP_MAX_MS, POR_MAX_MS, 0, 0, PERIPH_MAX_MS, LINK_MAX_MS};
   localparam bit          CMIN [NWIN] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam bit          CMAX [NWIN] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

   if (POR_MIN_MS > POR_MAX_MS) begin : g_bad_por
      $error("POR_MIN_MS exceeds POR_MAX_MS");
   end

   logic            ms_tick;
   logic [NSIG-1:0] lvl, rise, fall;
   logic [NWIN-1:0] w_open, w_close, w_bad;
   logic            done_q;

   lpm_tick_gen #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick)
   );

   always_comb begin
      lvl         = '0;
      lvl[S_SUPG] = supplies_good;
      lvl[S_POR]  = por_released;
      lvl[S_HOST] = host_rst_n;
      lvl[S_PERI] = periph_ready;
      lvl[S_TRN]  = link_training;
      lvl[S_LINK] = link_up;
   end

   // host reset lane starts at 1 so a low level out of reset reads as a fall
   lpm_edge_det #(.N(NSIG), .INIT(NSIG'(1) << S_HOST)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall)
   );

   always_comb begin
      w_open            = '0;
      w_close           = '0;
      w_open[W_RAMP]    = ramp_start;
      w_close[W_RAMP]   = rise[S_SUPG];
      w_open[W_POR]     = rise[S_SUPG];
      w_close[W_POR]    = rise[S_POR];
      w_open[W_HRST]    = fall[S_HOST];
      w_close[W_HRST]   = rise[S_HOST];
      w_open[W_QUIET]   = rise[S_HOST];
      w_close[W_QUIET]  = rise[S_TRN];
      w_open[W_PERIPH]  = ramp_start;
      w_close[W_PERIPH] = rise[S_PERI];
      w_open[W_LINK]    = rise[S_HOST];
      w_close[W_LINK]   = rise[S_LINK];
   end

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      lpm_window #(
         .TW(TW), .MIN_MS(LMIN[g]), .MAX_MS(LMAX[g]),
         .CHECK_MIN(CMIN[g]), .CHECK_MAX(CMAX[g])
      ) u_win (
         .clk(clk), .rst_n(rst_n), .clr(viol_clr), .ms_tick(ms_tick),
         .open_ev(w_open[g]), .close_ev(w_close[g]), .bad(w_bad[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       done_q <= 1'b0;
      else if (link_up) done_q <= 1'b1;
   end

   assign viol     = w_bad;
   assign seq_done = done_q;
   assign seq_pass = done_q & ~(|w_bad);
endmodule

// File: rtl/lpm_pwrup_mon_chk.sv
module lpm_pwrup_mon_chk #(
   parameter int unsigned NWIN = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            viol_clr,
   input logic            host_rst_n,
   input logic            link_training,
   input logic            link_up,
   input logic [NWIN-1:0] viol,
   input logic            seq_done,
   input logic            seq_pass
);
   // R7: set bits persist without a clear
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !viol_clr |=> ((viol & $past(viol)) == $past(viol)));

   // R7: a clear empties the vector
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      viol_clr |=> (viol == '0));

   // R8: link-active seen makes done high next cycle
   p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |=> seq_done);

   // R8: done holds
   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> seq_done);

   // R3: short-reset bit only follows a host reset release
   p_hrst_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol[2]) |-> $past(host_rst_n));

   // R4: early-training bit only follows training start
   p_quiet_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol[3]) |-> $past(link_training));

   // R9: a violation excludes pass
   p_pass_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (viol != '0) |-> !seq_pass);
endmodule

bind lpm_pwrup_mon lpm_pwrup_mon_chk #(.NWIN(lpm_pkg::NWIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .viol_clr(viol_clr), .host_rst_n(host_rst_n),
   .link_training(link_training), .link_up(link_up), .viol(viol),
   .seq_done(seq_done), .seq_pass(seq_pass)
);

// File: tb/lpm_pwrup_mon_bench.sv
module lpm_pwrup_mon_bench;
   localparam int unsigned TPM = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       viol_clr = 1'b0;
   logic       ramp_start = 1'b0;
   logic       supplies_good = 1'b0;
   logic       por_released = 1'b0;
   logic       host_rst_n = 1'b0;
   logic       periph_ready = 1'b0;
   logic       link_training = 1'b0;
   logic       link_up = 1'b0;
   logic [5:0] viol;
   logic       seq_done;
   logic       seq_pass;

   int n_checks = 0;
   int n_errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [5:0] v;
      logic       d;
      logic       p;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   lpm_pwrup_mon #(.TICKS_PER_MS(TPM)) u_lpm_pwrup_mon (
      .clk(clk), .rst_n(rst_n), .viol_clr(viol_clr), .ramp_start(ramp_start),
      .supplies_good(supplies_good), .por_released(por_released),
      .host_rst_n(host_rst_n), .periph_ready(periph_ready),
      .link_training(link_training), .link_up(link_up),
      .viol(viol), .seq_done(seq_done), .seq_pass(seq_pass)
   );

   // monitor: compares queued expectations shortly after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (viol !== e.v || seq_done !== e.d || seq_pass !== e.p) begin
               n_errors++;
               $display("FAIL %s: viol=%b done=%b pass=%b expected viol=%b done=%b pass=%b",
                        e.tag, viol, seq_done, seq_pass, e.v, e.d, e.p);
            end
         end
      end
   end

   task automatic expect_state(input logic [5:0] v, input logic d, input logic p, input string tag);
      exp_t e;
      e.v = v; e.d = d; e.p = p; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
   endtask

   // R10: one ms of stimulus equals TPM clock cycles
   task automatic wait_ms(input int n);
      repeat (n * TPM) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; viol_clr = 1'b0; ramp_start = 1'b0; supplies_good = 1'b0;
      por_released = 1'b0; host_rst_n = 1'b0; periph_ready = 1'b0;
      link_training = 1'b0; link_up = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic strobe();
      ramp_start = 1'b1;
      @(negedge clk);
      ramp_start = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            finish_run();
         end
      end
   end

   initial begin
      // ---- scenario A: compliant sequence ----
      do_reset();
      expect_state(6'b0, 1'b0, 1'b0, "R11 reset state");
      wait_ms(1);
      strobe();
      wait_ms(5);  supplies_good = 1'b1;
      wait_ms(8);  por_released = 1'b1;
      wait_ms(20); periph_ready = 1'b1;
      wait_ms(80); host_rst_n = 1'b1;
      wait_ms(25); link_training = 1'b1;
      wait_ms(10);
      expect_state(6'b0, 1'b0, 1'b0, "R1 R2 R3 R4 R5 compliant, done low before link");
      link_up = 1'b1;
      wait_ms(1);
      expect_state(6'b0, 1'b1, 1'b1, "R6 R8 R9 compliant pass");

      // ---- scenario B: every interval broken ----
      do_reset();
      wait_ms(1);
      strobe();
      wait_ms(15); supplies_good = 1'b1;
      expect_state(6'b000001, 1'b0, 1'b0, "R1 slow ramp");
      wait_ms(2);  por_released = 1'b1;
      wait_ms(1);
      expect_state(6'b000011, 1'b0, 1'b0, "R2 early POR release");
      wait_ms(50); host_rst_n = 1'b1;
      wait_ms(1);
      expect_state(6'b000111, 1'b0, 1'b0, "R3 short host reset");
      wait_ms(5);  link_training = 1'b1;
      wait_ms(1);
      expect_state(6'b001111, 1'b0, 1'b0, "R4 early training, R5 R6 not yet late");
      wait_ms(60);
      expect_state(6'b011111, 1'b0, 1'b0, "R5 periphery late");
      wait_ms(50);
      expect_state(6'b111111, 1'b0, 1'b0, "R6 link late, R7 sticky");
      viol_clr = 1'b1;
      @(negedge clk);
      viol_clr = 1'b0;
      expect_state(6'b0, 1'b0, 1'b0, "R7 clear");
      por_released = 1'b0;
      @(negedge clk);
      por_released = 1'b1;
      wait_ms(2);
      expect_state(6'b0, 1'b0, 1'b0, "R12 idle closing edge ignored");
      link_up = 1'b1;
      @(negedge clk);
      expect_state(6'b0, 1'b1, 1'b1, "R8 R9 pass after clear");
      link_up = 1'b0;
      wait_ms(1);
      expect_state(6'b0, 1'b1, 1'b1, "R8 done holds");

      // ---- scenario C: POR too late ----
      do_reset();
      wait_ms(1);
      strobe();
      wait_ms(3);  supplies_good = 1'b1;
      wait_ms(10);
      expect_state(6'b0, 1'b0, 1'b0, "R2 inside POR window");
      wait_ms(10); por_released = 1'b1;
      wait_ms(1);
      expect_state(6'b000010, 1'b0, 1'b0, "R2 late POR release");
      wait_ms(5);
      expect_state(6'b000010, 1'b0, 1'b0, "R7 late bit stays");

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule